// File: doc/BRIEF.md
# Masked Write Fill-Value Generator

This block prepares one burst for a masked write to a memory device with a 16-lane data bus and 16 transfers per burst. A burst carries 256 bits. The block groups them into 32 bytes. A byte is the eight bits that one lane carries during one clock period of the memory clock, and eight transfers make one clock period. Alongside the data comes one write enable per byte.

The masked write command does not carry a per-byte enable bitmap. It carries one 8-bit fill value instead. That value must not match any byte that is really written, and every byte that is not to be written is set to it. The block builds a 256-entry presence vector from the enabled bytes and picks the lowest value that is absent from it. It then overwrites the disabled bytes with that value and returns the modified burst with the fill value. It also raises a flag when a masked write is needed, which is the case when at least one byte is disabled.

The block has two register stages. It accepts a new burst on every cycle, and each result appears with a valid strobe.

Top module: `mwf_fill_gen`

## Requirements
- R1: `outValid` is high exactly two clock cycles after a cycle in which `inValid` is high, and low otherwise. Reset drives `outValid`, `outData`, `outMask` and `outMaskedNeeded` to zero.
- R2: Byte b = c*LANES + l is lane l in clock period c. Its bit k is burst bit (c*8 + k)*LANES + l, where transfer t occupies bits t*LANES .. t*LANES+LANES-1 and lane l is bit l within a transfer. An enabled byte (`inByteEn[b]` = 1) appears unchanged in `outData`.
- R3: Every disabled byte in `outData` equals `outMask`. Mask bit k goes to transfer c*8 + k, so bit 0 is the first transfer of the period and bit 7 the last.
- R4: `outMask` differs from every enabled byte of the same burst.
- R5: `outMask` is the numerically lowest 8-bit value that no enabled byte holds.
- R6: `outMaskedNeeded` is 1 exactly when at least one byte of the burst is disabled. When all bytes are enabled, the data passes unchanged and the R5 value is still reported.
- R7: When every byte is disabled, `outMask` is 0 and `outData` is all zeros.
- R8: Bursts on consecutive cycles are each processed independently, so one result is produced per cycle.
- R9: In cycles where `outValid` is low, `outData`, `outMask` and `outMaskedNeeded` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Burst on `inData`/`inByteEn` is valid this cycle |
| inData | input | LANES*BEATS (256) | Burst write data, transfer-major layout |
| inByteEn | input | LANES*BEATS/8 (32) | Per-byte write enable |
| outValid | output | 1 | Result valid strobe |
| outData | output | LANES*BEATS (256) | Burst with disabled bytes filled |
| outMask | output | 8 | Fill value for the command |
| outMaskedNeeded | output | 1 | At least one byte was disabled |

## Verification
The bench uses the default parameters of 16 lanes and 16 transfers. This gives the full 32 bytes, so the fill value can be pushed as high as 32 by enabling bytes that hold 0 through 31. Directed bursts cover that case, a burst with every byte disabled, a burst with every byte enabled, and small values clustered near zero. Random bursts with random enables, some back to back and some with gaps, exercise the lane-and-period byte mapping and the holding of outputs between results.

// File: rtl/mwf_pkg.sv
package mwf_pkg;
  localparam int BYTE_W = 8;
  localparam int VALS   = 1 << BYTE_W;

  typedef struct packed {
    logic s1Load;
    logic s2Load;
  } mwf_ctrl_t;
endpackage

// File: rtl/mwf_ctrl.sv
module mwf_ctrl
  import mwf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output mwf_ctrl_t ctrl,
  output logic      outValid
);
  logic vld1;
  logic vld2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld1 <= 1'b0;
      vld2 <= 1'b0;
    end else begin
      vld1 <= inValid;
      vld2 <= vld1;
    end
  end

  always_comb begin
    ctrl.s1Load = inValid;
    ctrl.s2Load = vld1;
  end

  assign outValid = vld2;
endmodule

// File: rtl/mwf_datapath.sv
module mwf_datapath
  import mwf_pkg::*;
#(
  parameter int LANES = 16,
  parameter int BEATS = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mwf_ctrl_t                ctrl,
  input  logic [LANES*BEATS-1:0]   inData,
  input  logic [LANES*BEATS/8-1:0] inByteEn,
  output logic [LANES*BEATS-1:0]   outData,
  output logic [BYTE_W-1:0]        outMask,
  output logic                     outMaskedNeeded
);
  localparam int CYC = BEATS / BYTE_W;
  localparam int NB  = LANES * CYC;
  localparam int W   = LANES * BEATS;

  logic [BYTE_W-1:0] inByte [NB];
  logic [VALS-1:0]   present;
  logic [W-1:0]      s1Data;
  logic [NB-1:0]     s1En;
  logic [VALS-1:0]   s1Present;
  logic [BYTE_W-1:0] fillVal;
  logic [W-1:0]      filled;

  // Gather per-lane bytes across the transfers of each clock period.
  for (genvar c = 0; c < CYC; c++) begin : g_cyc
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
        localparam int BI = (c * BYTE_W + k) * LANES + l;
        assign inByte[c*LANES+l][k] = inData[BI];
        assign filled[BI] = s1En[c*LANES+l] ? s1Data[BI] : fillVal[k];
      end
    end
  end

  always_comb begin
    present = '0;
    for (int b = 0; b < NB; b++) begin
      if (inByteEn[b]) present[inByte[b]] = 1'b1;
    end
  end

  always_comb begin
    fillVal = '0;
    for (int v = VALS - 1; v >= 0; v--) begin
      if (!s1Present[v]) fillVal = BYTE_W'(v);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Data    <= '0;
      s1En      <= '0;
      s1Present <= '0;
    end else if (ctrl.s1Load) begin
      s1Data    <= inData;
      s1En      <= inByteEn;
      s1Present <= present;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData         <= '0;
      outMask         <= '0;
      outMaskedNeeded <= 1'b0;
    end else if (ctrl.s2Load) begin
      outData         <= filled;
      outMask         <= fillVal;
      outMaskedNeeded <= ~&s1En;
    end
  end
endmodule

// File: rtl/mwf_fill_gen.sv
module mwf_fill_gen
  import mwf_pkg::*;
#(
  parameter int LANES = 16,
  parameter int BEATS = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [LANES*BEATS-1:0]   inData,
  input  logic [LANES*BEATS/8-1:0] inByteEn,
  output logic                     outValid,
  output logic [LANES*BEATS-1:0]   outData,
  output logic [7:0]               outMask,
  output logic                     outMaskedNeeded
);
  mwf_ctrl_t ctrl;

  mwf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  mwf_datapath #(.LANES(LANES), .BEATS(BEATS)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .ctrl            (ctrl),
    .inData          (inData),
    .inByteEn        (inByteEn),
    .outData         (outData),
    .outMask         (outMask),
    .outMaskedNeeded (outMaskedNeeded)
  );
endmodule

// File: rtl/mwf_fill_chk.sv
module mwf_fill_chk #(
  parameter int LANES = 16,
  parameter int BEATS = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic [LANES*BEATS/8-1:0] inByteEn,
  input logic                     outValid,
  input logic [LANES*BEATS-1:0]   outData,
  input logic [7:0]               outMask,
  input logic                     outMaskedNeeded
);
  localparam int CYC = BEATS / 8;
  localparam int NB  = LANES * CYC;

  logic [NB-1:0] en1, en2;
  logic          enOk, fillOk;

  always_ff @(posedge clk) begin
    en1 <= inByteEn;
    en2 <= en1;
  end

  always_comb begin
    enOk   = 1'b1;
    fillOk = 1'b1;
    for (int b = 0; b < NB; b++) begin
      logic [7:0] v;
      for (int k = 0; k < 8; k++) begin
        v[k] = outData[((b / LANES) * 8 + k) * LANES + (b % LANES)];
      end
      if (en2[b] && v == outMask) enOk = 1'b0;
      if (!en2[b] && v != outMask) fillOk = 1'b0;
    end
  end

  p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);
  p_mask_absent_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> enOk);
  p_fill_bytes_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> fillOk);
  p_needed_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outMaskedNeeded == !(&en2)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outData) && $stable(outMask) && $stable(outMaskedNeeded)));
endmodule

bind mwf_fill_gen mwf_fill_chk #(.LANES(LANES), .BEATS(BEATS)) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .inValid         (inValid),
  .inByteEn        (inByteEn),
  .outValid        (outValid),
  .outData         (outData),
  .outMask         (outMask),
  .outMaskedNeeded (outMaskedNeeded)
);

// File: tb/sim_mwf_fill_gen.sv
module sim_mwf_fill_gen;
  localparam int LANES = 16;
  localparam int BEATS = 16;
  localparam int W     = LANES * BEATS;
  localparam int NB    = W / 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [W-1:0]  inData = '0;
  logic [NB-1:0] inByteEn = '0;
  logic          outValid;
  logic [W-1:0]  outData;
  logic [7:0]    outMask;
  logic          outMaskedNeeded;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  mwf_fill_gen #(.LANES(LANES), .BEATS(BEATS)) u0 (.*);

  function automatic logic [7:0] getByte(logic [W-1:0] d, int b);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[k] = d[((b / LANES) * 8 + k) * LANES + (b % LANES)];
    return v;
  endfunction

  function automatic logic [W-1:0] setByte(logic [W-1:0] d, int b, logic [7:0] v);
    for (int k = 0; k < 8; k++) d[((b / LANES) * 8 + k) * LANES + (b % LANES)] = v[k];
    return d;
  endfunction

  function automatic logic [7:0] expMask(logic [W-1:0] d, logic [NB-1:0] en);
    for (int v = 0; v < 256; v++) begin
      bit hit = 0;
      for (int b = 0; b < NB; b++) if (en[b] && getByte(d, b) == 8'(v)) hit = 1;
      if (!hit) return 8'(v);
    end
    return 8'h00;
  endfunction

  function automatic logic [W-1:0] expData(logic [W-1:0] d, logic [NB-1:0] en, logic [7:0] m);
    for (int b = 0; b < NB; b++) if (!en[b]) d = setByte(d, b, m);
    return d;
  endfunction

  // Reference pipeline, two stages, holding values between valid bursts
  logic         mV1 = 0, mV2 = 0;
  logic [W-1:0] mD1 = '0, mD2 = '0;
  logic [7:0]   mM1 = '0, mM2 = '0;
  logic         mN1 = 0, mN2 = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mV1 <= 0; mV2 <= 0; mD1 <= '0; mD2 <= '0; mM1 <= '0; mM2 <= '0; mN1 <= 0; mN2 <= 0;
    end else begin
      mV1 <= inValid;
      mV2 <= mV1;
      if (inValid) begin
        mM1 <= expMask(inData, inByteEn);
        mD1 <= expData(inData, inByteEn, expMask(inData, inByteEn));
        mN1 <= ~&inByteEn;
      end
      if (mV1) begin
        mD2 <= mD1; mM2 <= mM1; mN2 <= mN1;
      end
    end
  end

  task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare every cycle away from the rising edge
  always @(negedge clk) begin
    if (rstN) begin
      check(outValid == mV2, "R1 valid strobe", W'(outValid), W'(mV2));
      check(outMask == mM2, "R5 fill value (R4 lowest absent)", W'(outMask), W'(mM2));
      check(outData == mD2, mV2 ? "R2/R3 burst data" : "R9 held data", outData, mD2);
      check(outMaskedNeeded == mN2, "R6 masked-write flag", W'(outMaskedNeeded), W'(mN2));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send(logic [W-1:0] d, logic [NB-1:0] en);
    inValid = 1; inData = d; inByteEn = en;
    @(negedge clk);
    inValid = 0;
  endtask

  function automatic logic [W-1:0] randData();
    logic [W-1:0] d;
    for (int i = 0; i < W / 32; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  initial begin
    logic [W-1:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 / R9: reset state
    checks++; if (outValid !== 0 || outMask !== 0 || outData !== '0 || outMaskedNeeded !== 0) begin
      errors++; $display("FAIL R1 reset state actual=%b/%h expected=0/0", outValid, outMask);
    end
    rstN = 1;
    @(negedge clk);
    // R5: enabled bytes hold 0..31, so the lowest free value is 32
    d = '0;
    for (int b = 0; b < NB; b++) d = setByte(d, b, 8'(b));
    send(d, '1);
    // R7: all disabled, fill is 0 and data all zeros
    send(randData(), '0);
    // R4 / R5: values 0,1,2 present in enabled bytes, one byte disabled
    d = randData() | {W{1'b1}};
    d = setByte(d, 3, 8'd0); d = setByte(d, 17, 8'd1); d = setByte(d, 30, 8'd2);
    send(d, ~(NB'(1) << 5));
    // R2 bit mapping: single lane/period markers, all enabled
    d = '0; d = setByte(d, 0, 8'h01); d = setByte(d, NB-1, 8'h80);
    send(d, '1);
    repeat (3) @(negedge clk);
    // R8: back-to-back random bursts, then gaps (R9)
    for (int i = 0; i < 400; i++) begin
      logic [NB-1:0] en;
      en = (i % 3 == 0) ? NB'($urandom) : ~(NB'(1) << ($urandom % NB));
      inValid = ($urandom % 4) != 0;
      inData = randData();
      inByteEn = en;
      @(negedge clk);
    end
    inValid = 0;
    repeat (4) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule